// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block turns the operand reference of each instruction into one physical address in a unified 512-byte register space. The space is made of four banks of 128 bytes. A direct reference joins the two bank-select bits to the 7-bit address field of the instruction. Field value 0 is not a real location. It marks an indirect reference, and then the address comes from an 8-bit pointer register held inside the block, with a separate indirect-bank bit on top.

The upper 16 offsets of every bank are one common region. Any reference that lands there is folded onto the bank-0 copy. The pointer register itself sits at offset 0x04 and can be reached from every bank. A write that lands on it, directly or through the pointer, loads the write data into the pointer. An indirect reference whose pointer offset is itself zero cannot resolve to anything. The block marks such a read as returning zero and such a write as suppressed, and raises neither the memory read strobe nor the memory write strobe.

Every result is registered once. It comes out one clock after the request, with a valid flag, next to the read and write qualifiers. The memory array and the decode of the instruction sit outside this block.

Top module: `dmem_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `rd_en`, `wr_en`, `rd_zero` and `wr_sup` are 0, and the pointer holds 0x00. An indirect read issued right after reset therefore reports `rd_zero`=1.
- R2: A direct reference (field ≠ 0, offset outside 0x70–0x7F, offset ≠ 0x04) yields `phys_addr` = {`bank_sel`[1:0], `addr_field`[6:0]}. Bits 8:7 are the bank and bits 6:0 the offset.
- R3: Any resolved reference whose offset (bits 6:0) lies in 0x70–0x7F yields `phys_addr` = {2'b00, offset}, whatever its bank. This holds for direct and indirect references.
- R4: `addr_field` = 0 selects indirect mode. The unfolded address is then {`ind_bank`, pointer[7:0]}, after which R3 and R7 apply.
- R5: An indirect read whose pointer bits 6:0 are zero gives `rd_zero`=1 and `rd_en`=0. Every other read gives `rd_en`=1 and `rd_zero`=0.
- R6: An indirect write whose pointer bits 6:0 are zero gives `wr_sup`=1 and `wr_en`=0, and leaves the pointer unchanged. Every other write gives `wr_en`=1 and `wr_sup`=0.
- R7: Offset 0x04 in any bank, reached directly or indirectly, resolves to `phys_addr` 0x004. A write there loads `wdata` into the pointer at that clock edge, so an indirect reference in the very next cycle already uses the new value.
- R8: The results of a request with `acc_valid`=1 appear on the outputs one clock later with `out_valid`=1. Back-to-back requests give back-to-back results.
- R9: A cycle with `acc_valid`=0 gives `out_valid`=0 and all four qualifiers 0 one clock later. Any write presented in such a cycle leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | An operand reference is presented this cycle |
| acc_write | input | 1 | 1 = write reference, 0 = read reference |
| addr_field | input | 7 | Address field from the instruction; 0 selects indirect mode |
| bank_sel | input | 2 | Bank-select bits for direct references |
| ind_bank | input | 1 | Bank bit placed above the pointer in indirect references |
| wdata | input | 8 | Write data, loaded into the pointer when a write lands on it |
| out_valid | output | 1 | Registered results below belong to a request |
| phys_addr | output | 9 | Resolved physical address in the unified space |
| rd_en | output | 1 | Perform a memory read at `phys_addr` |
| wr_en | output | 1 | Perform a memory write at `phys_addr` |
| rd_zero | output | 1 | Read returns 0x00 and no memory read takes place |
| wr_sup | output | 1 | Write is discarded |

## Verification
The pointer is the only hidden state, and a wrong value in it shows up at the first indirect reference after the fault. That reference comes out one clock later with the wrong `phys_addr`, or with `rd_zero` or `wr_sup` set when it should not be, or clear when it should be set. The vectors therefore load the pointer and use it in the very next cycle. They also hit the shared-region edges at 0x6F and 0x70, and set pointer values whose offset is 0, 0x04 or in the shared region. A fault in the folding logic or in the strobe gating shows on the very next result, because each result carries its address and its qualifiers together.

// File: rtl/dmem_addr_pkg.sv
package dmem_addr_pkg;
  localparam int unsigned OFS_W       = 7;
  localparam int unsigned BANK_W      = 2;
  localparam int unsigned ADDR_W      = BANK_W + OFS_W;
  localparam int unsigned PTR_W       = ADDR_W - 1;
  localparam int unsigned SHARED_SIZE = 16;
  localparam int unsigned SHARED_BASE = (1 << OFS_W) - SHARED_SIZE;
  localparam int unsigned PTR_OFS     = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              wr;
    logic              rzero;
    logic              wsup;
    logic              ptr_hit;
  } resolve_t;
endpackage

// File: rtl/dmem_ptr_reg.sv
module dmem_ptr_reg
  import dmem_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PTR_W-1:0] data_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i) ptr_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R7
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ptr_q == $past(data_i));
  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ptr_q));
endmodule

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve
  import dmem_addr_pkg::*;
(
  input  logic              write_i,
  input  logic [OFS_W-1:0]  field_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ind_bank_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output resolve_t          res_o
);
  logic              indirect;
  logic              null_ref;
  logic [ADDR_W-1:0] raw_addr;
  logic [OFS_W-1:0]  ofs;
  logic              fold;

  always_comb begin
    indirect = (field_i == '0);
    raw_addr = indirect ? {ind_bank_i, ptr_i} : {bank_i, field_i};
    ofs      = raw_addr[OFS_W-1:0];
    null_ref = indirect && (ptr_i[OFS_W-1:0] == '0);
    fold     = (32'(ofs) >= SHARED_BASE) || (32'(ofs) == PTR_OFS);

    res_o.addr    = fold ? {{BANK_W{1'b0}}, ofs} : raw_addr;
    res_o.rd      = !write_i && !null_ref;
    res_o.rzero   = !write_i &&  null_ref;
    res_o.wr      =  write_i && !null_ref;
    res_o.wsup    =  write_i &&  null_ref;
    res_o.ptr_hit = (32'(ofs) == PTR_OFS) && !null_ref;
  end
endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dmem_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [OFS_W-1:0]  addr_field,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ind_bank,
  input  logic [PTR_W-1:0]  wdata,
  output logic              out_valid,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              rd_en,
  output logic              wr_en,
  output logic              rd_zero,
  output logic              wr_sup
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [PTR_W-1:0]  ptr;
  logic              ptr_load;
  resolve_t          res;

  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [3:0]        qual_q, qual_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dmem_addr_resolve u_resolve (
    .write_i    (acc_write),
    .field_i    (addr_field),
    .bank_i     (bank_sel),
    .ind_bank_i (ind_bank),
    .ptr_i      (ptr),
    .res_o      (res)
  );

  assign ptr_load = acc_valid && res.wr && res.ptr_hit;

  dmem_ptr_reg u_ptr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (ptr_load),
    .data_i (wdata),
    .ptr_o  (ptr)
  );

  always_comb begin
    vld_d  = acc_valid;
    addr_d = addr_q;
    qual_d = 4'b0000;
    if (acc_valid) begin
      addr_d = res.addr;
      qual_d = {res.rd, res.wr, res.rzero, res.wsup};
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      qual_q <= 4'b0000;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      qual_q <= qual_d;
    end
  end

  assign out_valid = vld_q;
  assign phys_addr = addr_q;
  assign rd_en     = qual_q[3];
  assign wr_en     = qual_q[2];
  assign rd_zero   = qual_q[1];
  assign wr_sup    = qual_q[0];

  // R3
  shared_fold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && (32'(phys_addr[OFS_W-1:0]) >= SHARED_BASE))
      |-> (phys_addr[ADDR_W-1:OFS_W] == '0));
  // R5
  one_qual_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> $countones({rd_en, wr_en, rd_zero, wr_sup}) == 1);
  // R8
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_valid |=> out_valid);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !out_valid |-> !(rd_en || wr_en || rd_zero || wr_sup));
  // R6
  null_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && acc_write && addr_field == '0 && ptr[OFS_W-1:0] == '0)
      |=> (wr_sup && !wr_en && $stable(ptr)));
endmodule

// File: tb/dmem_addr_gen_tb.sv
module dmem_addr_gen_tb_top;
  logic       clk;
  logic       rst_n;
  logic       acc_valid;
  logic       acc_write;
  logic [6:0] addr_field;
  logic [1:0] bank_sel;
  logic       ind_bank;
  logic [7:0] wdata;
  logic       out_valid;
  logic [8:0] phys_addr;
  logic       rd_en, wr_en, rd_zero, wr_sup;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dmem_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .addr_field(addr_field), .bank_sel(bank_sel), .ind_bank(ind_bank),
    .wdata(wdata), .out_valid(out_valid), .phys_addr(phys_addr),
    .rd_en(rd_en), .wr_en(wr_en), .rd_zero(rd_zero), .wr_sup(wr_sup)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // wr, field, bank, ibank, wdata, exp addr, exp rd, wr, rzero, wsup
  typedef struct packed {
    logic       wr;
    logic [6:0] fld;
    logic [1:0] bank;
    logic       ib;
    logic [7:0] wd;
    logic [8:0] ea;
    logic       rd;
    logic       we;
    logic       rz;
    logic       ws;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    {1'b0, 7'h00, 2'd0, 1'b0, 8'h00, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 R5 ptr=0
    {1'b1, 7'h00, 2'd0, 1'b1, 8'h11, 9'h100, 1'b0, 1'b0, 1'b0, 1'b1}, // R6
    {1'b0, 7'h25, 2'd2, 1'b0, 8'h00, 9'h125, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
    {1'b1, 7'h33, 2'd3, 1'b0, 8'h00, 9'h1B3, 1'b0, 1'b1, 1'b0, 1'b0}, // R2
    {1'b0, 7'h75, 2'd3, 1'b0, 8'h00, 9'h075, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    {1'b1, 7'h7F, 2'd1, 1'b0, 8'h00, 9'h07F, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
    {1'b1, 7'h04, 2'd2, 1'b0, 8'hA5, 9'h004, 1'b0, 1'b1, 1'b0, 1'b0}, // R7
    {1'b0, 7'h00, 2'd0, 1'b0, 8'h00, 9'h0A5, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
    {1'b0, 7'h00, 2'd0, 1'b1, 8'h00, 9'h1A5, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
    {1'b1, 7'h04, 2'd1, 1'b0, 8'hF2, 9'h004, 1'b0, 1'b1, 1'b0, 1'b0}, // R7
    {1'b0, 7'h00, 2'd0, 1'b0, 8'h00, 9'h072, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 R4
    {1'b0, 7'h00, 2'd0, 1'b1, 8'h00, 9'h072, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 R4
    {1'b1, 7'h04, 2'd3, 1'b0, 8'h80, 9'h004, 1'b0, 1'b1, 1'b0, 1'b0}, // R7
    {1'b0, 7'h00, 2'd0, 1'b1, 8'h00, 9'h180, 1'b0, 1'b0, 1'b1, 1'b0}, // R5
    {1'b1, 7'h00, 2'd0, 1'b0, 8'h99, 9'h080, 1'b0, 1'b0, 1'b0, 1'b1}, // R6
    {1'b1, 7'h04, 2'd0, 1'b0, 8'h84, 9'h004, 1'b0, 1'b1, 1'b0, 1'b0}, // R7
    {1'b1, 7'h00, 2'd0, 1'b1, 8'h3C, 9'h004, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 indirect
    {1'b0, 7'h00, 2'd0, 1'b0, 8'h00, 9'h03C, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 R4
    {1'b0, 7'h04, 2'd1, 1'b0, 8'h00, 9'h004, 1'b1, 1'b0, 1'b0, 1'b0}, // R7
    {1'b0, 7'h6F, 2'd1, 1'b0, 8'h00, 9'h0EF, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 edge
    {1'b0, 7'h70, 2'd2, 1'b0, 8'h00, 9'h070, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 edge
    {1'b0, 7'h01, 2'd3, 1'b1, 8'h00, 9'h181, 1'b1, 1'b0, 1'b0, 1'b0}  // R2 ibank ignored
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [6:0] f,
                       input logic [1:0] b, input logic ib, input logic [7:0] d);
    acc_valid = v; acc_write = w; addr_field = f;
    bank_sel = b; ind_bank = ib; wdata = d;
  endtask

  task automatic check_out(input string req, input logic [8:0] ea,
                           input logic [3:0] q);
    check(req, "out_valid", 32'(out_valid), 32'd1);
    check(req, "phys_addr", 32'(phys_addr), 32'(ea));
    check(req, "qualifiers", 32'({rd_en, wr_en, rd_zero, wr_sup}), 32'(q));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 7'h00, 2'd0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", "out_valid", 32'(out_valid), 0);
    check("R1", "qualifiers", 32'({rd_en, wr_en, rd_zero, wr_sup}), 0);

    // vector walk, back to back (R8)
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, TBL[i].wr, TBL[i].fld, TBL[i].bank, TBL[i].ib, TBL[i].wd);
      @(negedge clk);
      check_out($sformatf("R8 vec%0d", i), TBL[i].ea,
                {TBL[i].rd, TBL[i].we, TBL[i].rz, TBL[i].ws});
    end

    // R9: idle cycle clears outputs; write on pointer without valid ignored
    drive(1'b0, 1'b1, 7'h04, 2'd0, 1'b0, 8'h55);
    @(negedge clk);
    check("R9", "out_valid", 32'(out_valid), 0);
    check("R9", "qualifiers", 32'({rd_en, wr_en, rd_zero, wr_sup}), 0);
    drive(1'b1, 1'b0, 7'h00, 2'd0, 1'b0, 8'h00);
    @(negedge clk);
    check_out("R9 pointer kept", 9'h03C, 4'b1000);

    // R6: suppressed write leaves pointer unchanged; load pointer 0x00 first
    drive(1'b1, 1'b1, 7'h04, 2'd1, 1'b0, 8'h00);
    @(negedge clk);
    drive(1'b1, 1'b1, 7'h00, 2'd0, 1'b0, 8'h77);
    @(negedge clk);
    check_out("R6", 9'h000, 4'b0001);
    drive(1'b1, 1'b0, 7'h00, 2'd0, 1'b1, 8'h00);
    @(negedge clk);
    check_out("R6 pointer kept", 9'h100, 4'b0010);

    // R1: reset again clears the pointer
    drive(1'b1, 1'b1, 7'h04, 2'd0, 1'b0, 8'h2B);
    @(negedge clk);
    do_reset();
    check("R1", "out_valid after reset", 32'(out_valid), 0);
    drive(1'b1, 1'b0, 7'h00, 2'd0, 1'b0, 8'h00);
    @(negedge clk);
    check_out("R1 pointer cleared", 9'h000, 4'b0010);
    drive(1'b0, 1'b0, 7'h00, 2'd0, 1'b0, 8'h00);
    @(negedge clk);
    check("R8", "single-cycle valid", 32'(out_valid), 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule